// File: doc/BRIEF.md
# Asynchronous Transmit Sequencer with Header Insertion

This block controls the transmit side of a serial-bus link layer. It sends one asynchronous packet per request. Software loads four 32-bit header quadlets into a small register bank. It then sets the payload length and raises `ready_i`. The sequencer presents the four headers to the link core, one per link-core take strobe. It then marks the start of the payload with a one-cycle prefix pulse. After that it reads each payload quadlet from the host over a 16-bit data port, in two halves, and hands each assembled quadlet to the link core.

Once the link core has taken the last quadlet, the sequencer waits for the destination node's immediate acknowledge. If the acknowledge carries the "complete" code, the sequencer raises `done_o` again and returns to idle. If the code is wrong, or no acknowledge arrives within a programmable number of cycles, the sequencer enters a disabled state. In that state `err_o` is high and new requests are ignored. It leaves the disabled state only on `clr_err_i` or a synchronous reset.

The state machine has eight states:
- IDLE: waiting for a request.
- HDR: presenting headers.
- PRE: prefix pulse.
- FETCH_HI: reading the upper half of a quadlet.
- FETCH_LO: reading the lower half of a quadlet.
- PUSH: offering the assembled quadlet to the link core.
- ACK_WAIT: waiting for the acknowledge.
- DISABLED: error latched.

The transitions are:
- IDLE→HDR when `ready_i` is high.
- HDR→HDR when `lk_take_i` is high on headers 0 to 2.
- HDR→PRE when header 3 is taken.
- PRE→FETCH_HI unconditionally.
- FETCH_HI→FETCH_LO unconditionally.
- FETCH_LO→PUSH unconditionally.
- PUSH→FETCH_HI when a quadlet other than the last is taken.
- PUSH→ACK_WAIT when the last quadlet is taken.
- ACK_WAIT→IDLE on a good acknowledge.
- ACK_WAIT→DISABLED on a bad acknowledge or a timeout.
- DISABLED→IDLE on `clr_err_i`.

Top module: `atx_seq`

## Requirements
- R1: After synchronous reset, `done_o`=1, and `err_o`, `rw_o`, `pre_o` and `lk_valid_o` are all 0.
- R2: When `ready_i` is sampled high in IDLE, `done_o` is 0 from the next cycle until the packet completes.
- R3: Header slot k (k = 0..3) is written through `hdr_we_i`, `hdr_sel_i`=k and `hdr_wdata_i`. During a packet the slots appear on `lk_data_o` with `lk_valid_o`=1 in the order 0,1,2,3. Each slot is held until a cycle with `lk_take_i`=1.
- R4: `pre_o` is high for exactly one cycle. That cycle follows the take of header 3 and immediately precedes the first `rw_o` cycle.
- R5: For each payload quadlet, `rw_o` is high for two consecutive cycles. `dmd_i` sampled in the first cycle forms bits 31:16 and in the second cycle bits 15:0. The quadlet is then held on `lk_data_o` with `lk_valid_o`=1 and `rw_o`=0 until taken.
- R6: The payload length is `qcnt_i`, sampled with the request. A value of 0 is treated as 1.
- R7: An acknowledge (`ack_valid_i`=1) whose `ack_code_i` equals the complete code (default 4'h1) returns the block to IDLE, with `done_o`=1 and `err_o`=0 in the next cycle.
- R8: An acknowledge with any other code sets `err_o`=1 in the next cycle, and `done_o` stays 0.
- R9: If no acknowledge arrives during the first ACK_TIMEOUT cycles of ACK_WAIT, `err_o` becomes 1 in the following cycle.
- R10: While `err_o`=1, `ready_i` is ignored: `done_o`, `rw_o` and `lk_valid_o` stay 0 and `err_o` stays 1.
- R11: While `err_o`=1, a cycle with `clr_err_i`=1 gives `err_o`=0 and `done_o`=1 in the next cycle.
- R12: A synchronous reset also clears the error state and empties the header slots to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | data-mover clock |
| rst | input | 1 | synchronous reset, active high |
| ready_i | input | 1 | packet request |
| qcnt_i | input | QCW | payload quadlets for the request |
| hdr_we_i | input | 1 | header slot write enable |
| hdr_sel_i | input | 2 | header slot index |
| hdr_wdata_i | input | 32 | header write data |
| rw_o | output | 1 | host read strobe |
| dmd_i | input | 16 | host payload data half |
| pre_o | output | 1 | one-cycle prefix pulse |
| done_o | output | 1 | high when idle and ready for a request |
| err_o | output | 1 | acknowledge failure, block disabled |
| clr_err_i | input | 1 | clears the error state |
| lk_valid_o | output | 1 | quadlet offered to link core |
| lk_data_o | output | 32 | offered quadlet |
| lk_take_i | input | 1 | link core takes offered quadlet |
| ack_valid_i | input | 1 | acknowledge received |
| ack_code_i | input | 4 | acknowledge code |

## Verification
The bench builds the block with ACK_TIMEOUT = 8 and QCW = 4. The short timeout lets the missing-acknowledge path be reached and its exact expiry cycle checked within a few cycles. The narrow length field makes the zero-length case and multi-quadlet packets cheap to run. The bench also stalls header and payload takes, to show that offered quadlets are held until taken.

// File: rtl/atx_pkg.sv
package atx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_PRE,
        S_FETCH_HI,
        S_FETCH_LO,
        S_PUSH,
        S_ACK_WAIT,
        S_DISABLED
    } atx_state_t;
endpackage

// File: rtl/atx_hdr_bank.sv
module atx_hdr_bank #(
    parameter int NHDR = 4,
    parameter int QW   = 32,
    localparam int SW  = $clog2(NHDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [QW-1:0] wdata,
    input  logic [SW-1:0] rsel,
    output logic [QW-1:0] rdata
);
    logic [QW-1:0] slot_q [NHDR];

    for (genvar g = 0; g < NHDR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (we && wsel == SW'(g))
                slot_q[g] <= wdata;
        end
    end

    assign rdata = slot_q[rsel];
endmodule

// File: rtl/atx_quad_asm.sv
module atx_quad_asm #(
    parameter int HW = 16,
    localparam int QW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_hi,
    input  logic          cap_lo,
    input  logic [HW-1:0] din,
    output logic [QW-1:0] quad
);
    logic [HW-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= din;
            if (cap_lo) lo_q <= din;
        end
    end

    assign quad = {hi_q, lo_q};

    // R5
    a_hi_lo_order_chk: assert property (@(posedge clk) disable iff (rst)
        cap_lo |-> $past(cap_hi));
endmodule

// File: rtl/atx_ack_timer.sv
module atx_ack_timer #(
    parameter int LIMIT = 64,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    logic [W-1:0] cnt_q;

    assign expired = run && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // R9
    a_timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < LIMIT);
endmodule

// File: rtl/atx_seq.sv
module atx_seq
    import atx_pkg::*;
#(
    parameter int         QCW          = 8,
    parameter int         HW           = 16,
    parameter int         ACK_TIMEOUT  = 64,
    parameter logic [3:0] ACK_COMPLETE = 4'h1,
    localparam int        QW           = 2 * HW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ready_i,
    input  logic [QCW-1:0] qcnt_i,
    input  logic           hdr_we_i,
    input  logic [1:0]     hdr_sel_i,
    input  logic [QW-1:0]  hdr_wdata_i,
    output logic           rw_o,
    input  logic [HW-1:0]  dmd_i,
    output logic           pre_o,
    output logic           done_o,
    output logic           err_o,
    input  logic           clr_err_i,
    output logic           lk_valid_o,
    output logic [QW-1:0]  lk_data_o,
    input  logic           lk_take_i,
    input  logic           ack_valid_i,
    input  logic [3:0]     ack_code_i
);
    atx_state_t     state_q, state_d;
    logic [1:0]     hidx_q;
    logic [QCW-1:0] qidx_q, qlast_q;
    logic [QW-1:0]  hdr_rd, quad;
    logic           tmr_expired;

    atx_hdr_bank #(.NHDR(4), .QW(QW)) u_hdr (
        .clk(clk), .rst(rst), .we(hdr_we_i), .wsel(hdr_sel_i),
        .wdata(hdr_wdata_i), .rsel(hidx_q), .rdata(hdr_rd)
    );

    atx_quad_asm #(.HW(HW)) u_asm (
        .clk(clk), .rst(rst),
        .cap_hi(state_q == S_FETCH_HI), .cap_lo(state_q == S_FETCH_LO),
        .din(dmd_i), .quad(quad)
    );

    atx_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_tmr (
        .clk(clk), .rst(rst), .clr(state_q != S_ACK_WAIT),
        .run(state_q == S_ACK_WAIT), .expired(tmr_expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (ready_i) state_d = S_HDR;
            S_HDR:      if (lk_take_i && hidx_q == 2'd3) state_d = S_PRE;
            S_PRE:      state_d = S_FETCH_HI;
            S_FETCH_HI: state_d = S_FETCH_LO;
            S_FETCH_LO: state_d = S_PUSH;
            S_PUSH:     if (lk_take_i)
                            state_d = (qidx_q == qlast_q) ? S_ACK_WAIT : S_FETCH_HI;
            S_ACK_WAIT: if (ack_valid_i)
                            state_d = (ack_code_i == ACK_COMPLETE) ? S_IDLE : S_DISABLED;
                        else if (tmr_expired)
                            state_d = S_DISABLED;
            S_DISABLED: if (clr_err_i) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            hidx_q  <= '0;
            qidx_q  <= '0;
            qlast_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && ready_i) begin
                hidx_q  <= '0;
                qidx_q  <= '0;
                qlast_q <= (qcnt_i == '0) ? '0 : qcnt_i - 1'b1;
            end
            if (state_q == S_HDR && lk_take_i)
                hidx_q <= hidx_q + 1'b1;
            if (state_q == S_PUSH && lk_take_i)
                qidx_q <= qidx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        done_o     = (state_q == S_IDLE);
        err_o      = (state_q == S_DISABLED);
        pre_o      = (state_q == S_PRE);
        rw_o       = (state_q == S_FETCH_HI) || (state_q == S_FETCH_LO);
        lk_valid_o = (state_q == S_HDR) || (state_q == S_PUSH);
        lk_data_o  = (state_q == S_HDR) ? hdr_rd : quad;
    end

    // R2
    a_done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> $past(ready_i));
    // R4
    a_pre_single_chk: assert property (@(posedge clk) disable iff (rst)
        pre_o |=> (!pre_o && rw_o));
    // R5
    a_rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rw_o |-> (!lk_valid_o && !pre_o));
    // R10
    a_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && !clr_err_i) |=> (err_o && !done_o && !rw_o));
    // R11
    a_err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && clr_err_i) |=> (done_o && !err_o));
    // R8
    a_bad_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ACK_WAIT && ack_valid_i && ack_code_i != ACK_COMPLETE) |=> err_o);
endmodule

// File: tb/atx_seq_bench.sv
module atx_seq_bench;
    localparam int TMO = 8;
    localparam int QCW = 4;

    logic           clk = 0;
    logic           rst = 1;
    logic           ready_i = 0;
    logic [QCW-1:0] qcnt_i = '0;
    logic           hdr_we_i = 0;
    logic [1:0]     hdr_sel_i = '0;
    logic [31:0]    hdr_wdata_i = '0;
    logic           rw_o, pre_o, done_o, err_o, lk_valid_o;
    logic [15:0]    dmd_i = '0;
    logic           clr_err_i = 0;
    logic [31:0]    lk_data_o;
    logic           lk_take_i = 0;
    logic           ack_valid_i = 0;
    logic [3:0]     ack_code_i = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] hdr_m [4];

    always #4 clk = ~clk;

    atx_seq #(.QCW(QCW), .ACK_TIMEOUT(TMO)) u_atx_seq (
        .clk(clk), .rst(rst), .ready_i(ready_i), .qcnt_i(qcnt_i),
        .hdr_we_i(hdr_we_i), .hdr_sel_i(hdr_sel_i), .hdr_wdata_i(hdr_wdata_i),
        .rw_o(rw_o), .dmd_i(dmd_i), .pre_o(pre_o), .done_o(done_o),
        .err_o(err_o), .clr_err_i(clr_err_i), .lk_valid_o(lk_valid_o),
        .lk_data_o(lk_data_o), .lk_take_i(lk_take_i),
        .ack_valid_i(ack_valid_i), .ack_code_i(ack_code_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_ctl(input string req, input bit d, input bit e,
                           input bit rw, input bit p, input bit v);
        chk(req, "done_o", 32'(done_o), 32'(d));
        chk(req, "err_o", 32'(err_o), 32'(e));
        chk(req, "rw_o", 32'(rw_o), 32'(rw));
        chk(req, "pre_o", 32'(pre_o), 32'(p));
        chk(req, "lk_valid_o", 32'(lk_valid_o), 32'(v));
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 4; i++) hdr_m[i] = '0;
    endtask

    task automatic write_hdrs(input logic [31:0] base);
        for (int i = 0; i < 4; i++) begin
            hdr_we_i = 1; hdr_sel_i = 2'(i); hdr_wdata_i = base + 32'(i * 32'h0101);
            @(negedge clk);
            hdr_m[i] = base + 32'(i * 32'h0101);
        end
        hdr_we_i = 0;
    endtask

    // ack_mode: 0 complete, 1 wrong code, 2 timeout
    task automatic send_pkt(input int nq, input int ack_mode, input int ack_dly,
                            input logic [31:0] seed);
        int eff;
        logic [31:0] q;
        eff = (nq == 0) ? 1 : nq;
        chk("R2", "done idle", 32'(done_o), 32'd1);
        ready_i = 1; qcnt_i = QCW'(nq);
        @(negedge clk);
        ready_i = 0;
        chk_ctl("R2", 0, 0, 0, 0, 1);
        for (int h = 0; h < 4; h++) begin
            chk("R3", "hdr data", lk_data_o, hdr_m[h]);
            if (h == 1) begin
                @(negedge clk);
                chk_ctl("R3", 0, 0, 0, 0, 1);
                chk("R3", "hdr held", lk_data_o, hdr_m[h]);
            end
            lk_take_i = 1;
            @(negedge clk);
            lk_take_i = 0;
        end
        chk_ctl("R4", 0, 0, 0, 1, 0);
        @(negedge clk);
        for (int k = 0; k < eff; k++) begin
            q = seed + 32'(k) * 32'h1357_2468;
            chk_ctl("R5", 0, 0, 1, 0, 0);
            dmd_i = q[31:16];
            @(negedge clk);
            chk_ctl("R5", 0, 0, 1, 0, 0);
            dmd_i = q[15:0];
            @(negedge clk);
            dmd_i = 16'hDEAD;
            chk_ctl("R5", 0, 0, 0, 0, 1);
            chk("R5", "quad data", lk_data_o, q);
            if (k == 0) begin
                @(negedge clk);
                chk("R5", "quad held", lk_data_o, q);
            end
            lk_take_i = 1;
            @(negedge clk);
            lk_take_i = 0;
        end
        chk_ctl("R6", 0, 0, 0, 0, 0);
        if (ack_mode == 2) begin
            for (int c = 0; c < TMO; c++) begin
                chk_ctl("R9", 0, 0, 0, 0, 0);
                @(negedge clk);
            end
            chk_ctl("R9", 0, 1, 0, 0, 0);
        end else begin
            for (int c = 0; c < ack_dly; c++) begin
                @(negedge clk);
                chk_ctl("R7", 0, 0, 0, 0, 0);
            end
            ack_valid_i = 1;
            ack_code_i = (ack_mode == 0) ? 4'h1 : 4'h4;
            @(negedge clk);
            ack_valid_i = 0; ack_code_i = '0;
            if (ack_mode == 0) chk_ctl("R7", 1, 0, 0, 0, 0);
            else               chk_ctl("R8", 0, 1, 0, 0, 0);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk_ctl("R1", 1, 0, 0, 0, 0);
        write_hdrs(32'hA000_0010);
        send_pkt(1, 0, 2, 32'h1234_5678);
        send_pkt(3, 0, 0, 32'hCAFE_0001);
        send_pkt(0, 0, 1, 32'h0F0F_F0F0);   // R6: zero treated as one
        send_pkt(2, 1, 1, 32'h5555_AAAA);
        // R10: requests ignored while disabled
        ready_i = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_ctl("R10", 0, 1, 0, 0, 0);
        end
        ready_i = 0;
        clr_err_i = 1;
        @(negedge clk);
        clr_err_i = 0;
        chk_ctl("R11", 1, 0, 0, 0, 0);
        send_pkt(1, 2, 0, 32'h8765_4321);
        do_reset();
        chk_ctl("R12", 1, 0, 0, 0, 0);
        ready_i = 1; qcnt_i = 1;
        @(negedge clk);
        ready_i = 0;
        chk("R12", "hdr cleared", lk_data_o, 32'h0);
        do_reset();
        write_hdrs(32'h0B00_0000);
        send_pkt(2, 0, 3, 32'h2468_ACE0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule